// File: doc/BRIEF.md
# Receive Sample Filter and Formatter

This block sits between a serial audio receiver's subframe decoder and a 32-bit holding register that software or a DMA engine reads. Each decoded subframe arrives as a one-cycle strobe with up to 24 audio bits, the validity, user, channel-status and parity flags, and a start-of-block marker. The block decides whether the sample is kept, formats it and writes it into the holding register. It reports three one-cycle events: a word became ready, a parity error, and an overrun.

The keep-or-drop decision depends on the receive enable, the validity bit, the parity check and an optional wait for the first block-start marker. The sample width, the byte order and the packing of two 16-bit samples into one word can all be changed at run time. A read strobe consumes the held word.

Top module: `rxfmt_top`

## Requirements
- R1: While `rxEnable` is 0, no sample is loaded and `evReady`, `evParityErr` and `evOverrun` stay 0.
- R2: With `validityDiscard` at 1, a subframe whose validity bit is 1 is dropped. With `validityDiscard` at 0, the validity bit has no effect.
- R3: Parity is even over the 24 audio bits together with the validity, user, channel-status and parity bits. While `parityCheckOff` is 0, an odd total drops the sample and pulses `evParityErr`. While it is 1, the sample is loaded and no parity event is raised.
- R4: `widthSel` 0 selects 24 bits, 1 selects 20 bits, and 2 or 3 select 16 bits. The sample keeps the top bits of the audio field and sits right-aligned and zero-extended in `holdData`.
- R5: With `bigEndian` at 1, the bytes occupied by the sample are reversed: three bytes for 24 or 20 bits, two bytes for 16 bits. With `bigEndian` at 0, the bytes keep their order.
- R6: With `packEnable` at 1 and a 16-bit width, the first kept sample fills bits 15:0 and the second fills bits 31:16. `holdReady` rises only once both halves are filled. `packEnable` has no effect at other widths.
- R7: With `blockStartDiscard` at 1, samples are dropped from the moment receive is enabled until a subframe carrying the block-start marker arrives. That subframe and all later ones pass this filter.
- R8: A `readStrobe` while `holdReady` is 1 clears `holdReady`. When a read and a load fall in the same cycle, `holdReady` stays 1 and the new word is held.
- R9: When a word is loaded while `holdReady` is 1 and no read occurs in that cycle, `evOverrun` pulses and the new word replaces the old one.
- R10: After reset, `holdData`, `holdReady` and all events are 0. `holdData`, `holdReady` and the events update on the clock edge that samples the subframe strobe, and each event lasts one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rxEnable | input | 1 | Receive enable |
| validityDiscard | input | 1 | Drop samples whose validity bit is set |
| parityCheckOff | input | 1 | Disable the parity check |
| widthSel | input | 2 | Sample width code (0: 24, 1: 20, 2/3: 16 bits) |
| bigEndian | input | 1 | Reverse the byte order of the sample |
| packEnable | input | 1 | Pack two 16-bit samples per word |
| blockStartDiscard | input | 1 | Drop samples until the first block-start marker |
| sfValid | input | 1 | Subframe strobe |
| sfAudio | input | 24 | Audio bits, MSB-aligned |
| sfValidity | input | 1 | Validity flag of the subframe |
| sfUser | input | 1 | User bit of the subframe |
| sfChStat | input | 1 | Channel-status bit of the subframe |
| sfParity | input | 1 | Parity bit of the subframe |
| sfBlockStart | input | 1 | Subframe opens a block |
| readStrobe | input | 1 | Consume the holding register |
| holdData | output | 32 | Holding register |
| holdReady | output | 1 | Holding register holds an unread word |
| evReady | output | 1 | Pulse: a word was loaded |
| evParityErr | output | 1 | Pulse: parity error seen |
| evOverrun | output | 1 | Pulse: an unread word was overwritten |

## Verification
The assertions assume that `sfValid` is a single-cycle strobe with its fields stable in that cycle. They also assume that configuration inputs change only between subframes, and that packing is switched only while no half word is pending. The stimulus drives every input on the falling edge and changes configuration only between subframes. When it toggles packing or the enable, it does so after the held words have been read, so the pending half is always empty. Parity is computed in the stimulus from the fields being sent, and then inverted on purpose for the error cases.

// File: rtl/rxfmt_pkg.sv
package rxfmt_pkg;

  // Run-time configuration presented to the block
  typedef struct packed {
    logic       sbDiscard;
    logic       packEn;
    logic       bigEnd;
    logic [1:0] widthSel;
    logic       parityOff;
    logic       vDiscard;
    logic       rxEn;
  } rxCfg_t;

  // Strobes from control to datapath
  typedef struct packed {
    logic loadLow;   // store formatted sample into the low-half staging
    logic loadWord;  // commit a word to the holding register
    logic packWord;  // committed word is staging plus current half
  } dpStrobe_t;

endpackage

// File: rtl/rxfmt_ctrl.sv
module rxfmt_ctrl
  import rxfmt_pkg::*;
#(
  parameter int AUDIO_W = 24
) (
  input  logic               clk,
  input  logic               rst_n,
  input  rxCfg_t             cfg,
  input  logic               sfValid,
  input  logic [AUDIO_W-1:0] sfAudio,
  input  logic               sfValidity,
  input  logic               sfUser,
  input  logic               sfChStat,
  input  logic               sfParity,
  input  logic               sfBlockStart,
  input  logic               readStrobe,
  output dpStrobe_t          stb,
  output logic               holdReady,
  output logic               evReady,
  output logic               evParityErr,
  output logic               evOverrun
);

  logic badParity, enabled, parDrop, vDrop, sbDrop, accept, packMode;
  logic halfFull, waitBlock;

  assign badParity = ^{sfAudio, sfValidity, sfUser, sfChStat, sfParity};
  assign enabled   = sfValid & cfg.rxEn;
  assign parDrop   = ~cfg.parityOff & badParity;
  assign vDrop     = cfg.vDiscard & sfValidity;
  assign sbDrop    = cfg.sbDiscard & waitBlock & ~sfBlockStart;
  assign accept    = enabled & ~parDrop & ~vDrop & ~sbDrop;
  assign packMode  = cfg.packEn & cfg.widthSel[1];

  always_comb begin
    stb.loadLow  = accept & packMode & ~halfFull;
    stb.loadWord = accept & (~packMode | halfFull);
    stb.packWord = packMode & halfFull;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      halfFull    <= 1'b0;
      waitBlock   <= 1'b1;
      holdReady   <= 1'b0;
      evReady     <= 1'b0;
      evParityErr <= 1'b0;
      evOverrun   <= 1'b0;
    end else begin
      if (!cfg.rxEn) begin
        halfFull  <= 1'b0;
        waitBlock <= 1'b1;
      end else begin
        if (enabled && sfBlockStart) waitBlock <= 1'b0;
        if (stb.loadLow) halfFull <= 1'b1;
        else if (stb.loadWord) halfFull <= 1'b0;
      end
      holdReady   <= stb.loadWord | (holdReady & ~readStrobe);
      evReady     <= stb.loadWord;
      evParityErr <= enabled & parDrop;
      evOverrun   <= stb.loadWord & holdReady & ~readStrobe;
    end
  end

  // R1: a disabled receiver raises no events
  p_quiet_when_off_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(cfg.rxEn) |-> !(evReady || evParityErr || evOverrun));

  // R3: a parity error never produces a loaded word
  p_parity_no_load_r3: assert property (@(posedge clk) disable iff (!rst_n)
    evParityErr |-> !evReady);

  // R8: a read with no concurrent load empties the register
  p_read_clears_r8: assert property (@(posedge clk) disable iff (!rst_n)
    holdReady && readStrobe && !stb.loadWord |=> !holdReady);

  // R9: overrun only when a word was already waiting
  p_overrun_needs_ready_r9: assert property (@(posedge clk) disable iff (!rst_n)
    evOverrun |-> $past(holdReady) && holdReady);

  // R10: a ready event always leaves a word available
  p_ready_event_r10: assert property (@(posedge clk) disable iff (!rst_n)
    evReady |-> holdReady);

endmodule

// File: rtl/rxfmt_datapath.sv
module rxfmt_datapath
  import rxfmt_pkg::*;
#(
  parameter int AUDIO_W = 24,
  parameter int HOLD_W  = 32
) (
  input  logic               clk,
  input  logic               rst_n,
  input  rxCfg_t             cfg,
  input  dpStrobe_t          stb,
  input  logic [AUDIO_W-1:0] sfAudio,
  output logic [HOLD_W-1:0]  holdData
);

  localparam int HALF_W = HOLD_W / 2;
  localparam int NBYTE  = HOLD_W / 8;

  logic [HOLD_W-1:0] aligned, swapped;
  logic [HALF_W-1:0] stage;
  int                shiftAmt, nBytes;

  always_comb begin
    case (cfg.widthSel)
      2'd0:    begin shiftAmt = AUDIO_W - 24; nBytes = 3; end
      2'd1:    begin shiftAmt = AUDIO_W - 20; nBytes = 3; end
      default: begin shiftAmt = AUDIO_W - 16; nBytes = 2; end
    endcase
    aligned = {{(HOLD_W-AUDIO_W){1'b0}}, sfAudio} >> shiftAmt;
    swapped = aligned;
    if (cfg.bigEnd) begin
      for (int b = 0; b < NBYTE; b++) begin
        if (b < nBytes) swapped[8*b +: 8] = aligned[8*(nBytes-1-b) +: 8];
        else            swapped[8*b +: 8] = 8'h00;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      stage    <= '0;
      holdData <= '0;
    end else begin
      if (stb.loadLow) stage <= swapped[HALF_W-1:0];
      if (stb.loadWord)
        holdData <= stb.packWord ? {swapped[HALF_W-1:0], stage} : swapped;
    end
  end

  // R10: the holding register changes only on a commit
  p_hold_stable_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !stb.loadWord |=> $stable(holdData));

endmodule

// File: rtl/rxfmt_top.sv
module rxfmt_top
  import rxfmt_pkg::*;
#(
  parameter int AUDIO_W = 24,
  parameter int HOLD_W  = 32
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               rxEnable,
  input  logic               validityDiscard,
  input  logic               parityCheckOff,
  input  logic [1:0]         widthSel,
  input  logic               bigEndian,
  input  logic               packEnable,
  input  logic               blockStartDiscard,
  input  logic               sfValid,
  input  logic [AUDIO_W-1:0] sfAudio,
  input  logic               sfValidity,
  input  logic               sfUser,
  input  logic               sfChStat,
  input  logic               sfParity,
  input  logic               sfBlockStart,
  input  logic               readStrobe,
  output logic [HOLD_W-1:0]  holdData,
  output logic               holdReady,
  output logic               evReady,
  output logic               evParityErr,
  output logic               evOverrun
);

  rxCfg_t    cfg;
  dpStrobe_t stb;

  always_comb begin
    cfg.rxEn      = rxEnable;
    cfg.vDiscard  = validityDiscard;
    cfg.parityOff = parityCheckOff;
    cfg.widthSel  = widthSel;
    cfg.bigEnd    = bigEndian;
    cfg.packEn    = packEnable;
    cfg.sbDiscard = blockStartDiscard;
  end

  rxfmt_ctrl #(.AUDIO_W(AUDIO_W)) i_ctrl (
    .clk(clk), .rst_n(rst_n), .cfg(cfg), .sfValid(sfValid), .sfAudio(sfAudio),
    .sfValidity(sfValidity), .sfUser(sfUser), .sfChStat(sfChStat),
    .sfParity(sfParity), .sfBlockStart(sfBlockStart), .readStrobe(readStrobe),
    .stb(stb), .holdReady(holdReady), .evReady(evReady),
    .evParityErr(evParityErr), .evOverrun(evOverrun)
  );

  rxfmt_datapath #(.AUDIO_W(AUDIO_W), .HOLD_W(HOLD_W)) i_dp (
    .clk(clk), .rst_n(rst_n), .cfg(cfg), .stb(stb), .sfAudio(sfAudio),
    .holdData(holdData)
  );

endmodule

// File: tb/test_rxfmt_top.sv
module test_rxfmt_top;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        rxEnable = 0, validityDiscard = 0, parityCheckOff = 0;
  logic [1:0]  widthSel = 0;
  logic        bigEndian = 0, packEnable = 0, blockStartDiscard = 0;
  logic        sfValid = 0, sfValidity = 0, sfUser = 0, sfChStat = 0;
  logic        sfParity = 0, sfBlockStart = 0, readStrobe = 0;
  logic [23:0] sfAudio = '0;
  logic [31:0] holdData;
  logic        holdReady, evReady, evParityErr, evOverrun;

  int nChecks = 0;
  int nFail   = 0;
  int cycles  = 0;

  always #2 clk = ~clk;

  rxfmt_top i_rxfmt_top (
    .clk(clk), .rst_n(rst_n), .rxEnable(rxEnable),
    .validityDiscard(validityDiscard), .parityCheckOff(parityCheckOff),
    .widthSel(widthSel), .bigEndian(bigEndian), .packEnable(packEnable),
    .blockStartDiscard(blockStartDiscard), .sfValid(sfValid),
    .sfAudio(sfAudio), .sfValidity(sfValidity), .sfUser(sfUser),
    .sfChStat(sfChStat), .sfParity(sfParity), .sfBlockStart(sfBlockStart),
    .readStrobe(readStrobe), .holdData(holdData), .holdReady(holdReady),
    .evReady(evReady), .evParityErr(evParityErr), .evOverrun(evOverrun)
  );

  // {widthSel, bigEndian, audio, expected word}
  localparam logic [58:0] VECS [8] = '{
    {2'd0, 1'b0, 24'hABCDEF, 32'h00ABCDEF},
    {2'd0, 1'b1, 24'hABCDEF, 32'h00EFCDAB},
    {2'd1, 1'b0, 24'hABCDEF, 32'h000ABCDE},
    {2'd1, 1'b1, 24'hABCDEF, 32'h00DEBC0A},
    {2'd2, 1'b0, 24'hABCDEF, 32'h0000ABCD},
    {2'd2, 1'b1, 24'hABCDEF, 32'h0000CDAB},
    {2'd3, 1'b0, 24'h123456, 32'h00001234},
    {2'd0, 1'b1, 24'h123456, 32'h00563412}
  };

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    nChecks++;
    if (got !== exp) begin
      nFail++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  // drive one subframe, return after the edge that samples it
  task automatic sendSub(input logic [23:0] a, input logic v, input logic bs,
                         input logic flip);
    @(negedge clk);
    sfValid      = 1'b1;
    sfAudio      = a;
    sfValidity   = v;
    sfBlockStart = bs;
    sfParity     = (^{a, v, sfUser, sfChStat}) ^ flip;
    @(negedge clk);
    sfValid      = 1'b0;
  endtask

  task automatic readHold();
    @(negedge clk);
    readStrobe = 1'b1;
    @(negedge clk);
    readStrobe = 1'b0;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles == 20000) begin
      nFail++;
      $display("FAIL R10 watchdog: got %0d cycles expected fewer", cycles);
      $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R10 reset ready", {31'd0, holdReady}, 32'd0);
    chk("R10 reset data", holdData, 32'd0);
    chk("R10 reset events", {29'd0, evReady, evParityErr, evOverrun}, 32'd0);

    // R1: disabled, bad parity sample
    sendSub(24'h777777, 1'b0, 1'b0, 1'b1);
    chk("R1 no events", {29'd0, evReady, evParityErr, evOverrun}, 32'd0);
    chk("R1 no load", {31'd0, holdReady}, 32'd0);

    // R4 R5: width and byte order table
    rxEnable = 1'b1;
    for (int i = 0; i < 8; i++) begin
      @(negedge clk);
      widthSel  = VECS[i][58:57];
      bigEndian = VECS[i][56];
      sendSub(VECS[i][55:32], 1'b0, 1'b0, 1'b0);
      chk($sformatf("R4/R5 vec%0d data", i), holdData, VECS[i][31:0]);
      chk($sformatf("R10 vec%0d evReady", i), {31'd0, evReady}, 32'd1);
      readHold();
    end
    chk("R8 read clears", {31'd0, holdReady}, 32'd0);
    widthSel = 2'd0; bigEndian = 1'b0;

    // R2: validity filter
    validityDiscard = 1'b1;
    sendSub(24'h010203, 1'b1, 1'b0, 1'b0);
    chk("R2 drop V=1", {31'd0, holdReady}, 32'd0);
    sendSub(24'h040506, 1'b0, 1'b0, 1'b0);
    chk("R2 keep V=0", holdData, 32'h00040506);
    readHold();
    validityDiscard = 1'b0;
    sfUser = 1'b1;
    sendSub(24'h070809, 1'b1, 1'b0, 1'b0);
    chk("R2 mode off keeps V=1", {31'd0, holdReady}, 32'd1);
    chk("R2 mode off data", holdData, 32'h00070809);
    readHold();
    sfUser = 1'b0;

    // R3: parity
    sendSub(24'h0A0B0C, 1'b0, 1'b0, 1'b1);
    chk("R3 parity event", {31'd0, evParityErr}, 32'd1);
    chk("R3 parity drop", {31'd0, holdReady}, 32'd0);
    parityCheckOff = 1'b1;
    sendSub(24'h0D0E0F, 1'b0, 1'b0, 1'b1);
    chk("R3 check off no event", {31'd0, evParityErr}, 32'd0);
    chk("R3 check off load", holdData, 32'h000D0E0F);
    readHold();
    parityCheckOff = 1'b0;

    // R9: overrun
    sendSub(24'h111111, 1'b0, 1'b0, 1'b0);
    sendSub(24'h222222, 1'b0, 1'b0, 1'b0);
    chk("R9 overrun event", {31'd0, evOverrun}, 32'd1);
    chk("R9 new word kept", holdData, 32'h00222222);

    // R8: read and load in one cycle
    @(negedge clk);
    readStrobe = 1'b1;
    sfValid    = 1'b1;
    sfAudio    = 24'h333333;
    sfValidity = 1'b0; sfBlockStart = 1'b0;
    sfParity   = ^{24'h333333, 1'b0, sfUser, sfChStat};
    @(negedge clk);
    readStrobe = 1'b0;
    sfValid    = 1'b0;
    chk("R8 ready stays", {31'd0, holdReady}, 32'd1);
    chk("R8 no overrun", {31'd0, evOverrun}, 32'd0);
    chk("R8 data", holdData, 32'h00333333);
    readHold();
    chk("R8 cleared", {31'd0, holdReady}, 32'd0);

    // R6: packing
    widthSel = 2'd2; packEnable = 1'b1;
    sendSub(24'h111100, 1'b0, 1'b0, 1'b0);
    chk("R6 half not ready", {31'd0, holdReady}, 32'd0);
    sendSub(24'h222200, 1'b0, 1'b0, 1'b0);
    chk("R6 full ready", {31'd0, holdReady}, 32'd1);
    chk("R6 packed data", holdData, 32'h22221111);
    readHold();
    widthSel = 2'd0;
    sendSub(24'h565656, 1'b0, 1'b0, 1'b0);
    chk("R6 ignored at 24 bits", holdData, 32'h00565656);
    readHold();
    packEnable = 1'b0;

    // R7: block-start wait
    blockStartDiscard = 1'b1;
    rxEnable = 1'b0;
    @(negedge clk);
    rxEnable = 1'b1;
    sendSub(24'h454545, 1'b0, 1'b0, 1'b0);
    chk("R7 drop before marker", {31'd0, holdReady}, 32'd0);
    sendSub(24'h464646, 1'b0, 1'b1, 1'b0);
    chk("R7 marker loads", holdData, 32'h00464646);
    readHold();
    sendSub(24'h474747, 1'b0, 1'b0, 1'b0);
    chk("R7 after marker loads", holdData, 32'h00474747);
    chk("R7 after marker ready", {31'd0, holdReady}, 32'd1);
    readHold();

    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFail);
    $finish;
  end

endmodule